// File: doc/BRIEF.md
# UART Interrupt Request Combiner

This block merges the separate event conditions of a serial port into one active-low interrupt line for a host processor. Four of the conditions are status levels that are held elsewhere: transmit holding register empty, transmitter idle, receive data available and receive overrun. The block never changes those levels. The other two conditions have no status flag of their own. One is a single-cycle address-match event. The other is a falling edge on the raw receive pin, used to wake a sleeping host. The block latches these two into pending bits that the host clears with an acknowledge pulse.

Each transmit condition has its own enable. Both receive conditions share one receive enable. The address event has its own enable. A wake-up needs both the wake enable and the receive enable. The gated conditions appear on a pending vector. The block drives the interrupt line low for a short fixed pulse whenever the OR of the pending vector rises. It issues the pulse again at a fixed interval while anything stays pending. A master enable holds the line high and leaves the pending state untouched.

Top module: `uirq_combiner`

## Requirements
- R1: While reset is asserted and at the first sample after it is released, `int_n_o` is 1 and `pend_o` is all zero when every enable is 0.
- R2: `pend_o[0]` equals `tx_empty_i` AND `en_tx_empty_i`. `pend_o[1]` equals `tx_idle_i` AND `en_tx_idle_i`. A source whose enable is 0 causes no pulse.
- R3: `pend_o[2]` equals `rx_avail_i` AND `en_rx_i`, and `pend_o[3]` equals `rx_ovr_i` AND `en_rx_i`. One enable governs both bits.
- R4: A clock edge that samples `addr_evt_i`=1 with `en_addr_i`=1 sets `pend_o[4]`. The bit stays set until acknowledged. An event sampled while `en_addr_i`=0 leaves `pend_o[4]` at 0.
- R5: `rx_pin_i` passes through a two-flop synchronizer. A 1-to-0 transition sets `pend_o[5]` three edges after the first edge that samples the low pin, but only if `en_wake_i` and `en_rx_i` are both 1. A pin that stays low does not set the bit again.
- R6: An edge that samples `ack_i`=1 clears `pend_o[4]` and `pend_o[5]` and leaves bits 0 to 3 unchanged. If a new address or wake event arrives at the same edge as the acknowledge, the event wins and the bit stays set.
- R7: When the OR of `pend_o` goes from 0 to 1 at a clock edge with `master_en_i`=1, `int_n_o` is 0 for exactly the two cycles that follow that edge.
- R8: A further low pulse starts 64 clocks after the start of the previous pulse if any bit of `pend_o` is still 1 at that point.
- R9: While `master_en_i`=0, `int_n_o` is 1 from the next edge on, no pulse starts, and the pending bits are kept. When `master_en_i` returns to 1 at least 64 clocks after the last pulse and something is still pending, a pulse starts at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tx_empty_i | input | 1 | Transmit holding register empty level |
| tx_idle_i | input | 1 | Transmitter idle level |
| rx_avail_i | input | 1 | Receive data available level |
| rx_ovr_i | input | 1 | Receive overrun level |
| addr_evt_i | input | 1 | Single-cycle address match event |
| rx_pin_i | input | 1 | Raw asynchronous receive pin |
| en_tx_empty_i | input | 1 | Enable for transmit-empty source |
| en_tx_idle_i | input | 1 | Enable for transmitter-idle source |
| en_rx_i | input | 1 | Shared enable for both receive sources and for wake |
| en_addr_i | input | 1 | Enable for address event |
| en_wake_i | input | 1 | Enable for pin wake-up |
| master_en_i | input | 1 | Master enable; 0 holds the interrupt line high |
| ack_i | input | 1 | Clears the latched address and wake bits |
| int_n_o | output | 1 | Active-low interrupt pulse |
| pend_o | output | 6 | Gated pending sources, bit order as in R2 to R5 |

## Verification
The properties assume that the status levels, the enables and `ack_i` are synchronous to `clk` and change only between edges. Only `rx_pin_i` may be asynchronous. They also assume that `addr_evt_i` is a one-cycle strobe. The bench drives every input on the falling clock edge, so every input is stable around each rising edge. It raises the address strobe for exactly one cycle and changes the pin slowly enough that each edge reaches the synchronizer as a clean transition. Sources are removed, or acknowledged, before a repeat pulse is due unless a scenario is built to observe that repeat.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC      = 6;
  localparam int IDX_TXE   = 0;
  localparam int IDX_TXI   = 1;
  localparam int IDX_RXA   = 2;
  localparam int IDX_RXO   = 3;
  localparam int IDX_ADDR  = 4;
  localparam int IDX_WAKE  = 5;
endpackage

// File: rtl/uirq_rx_sync.sv
// Synchronizes the raw receive pin and flags one-cycle falling edges.
module uirq_rx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q, last_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], rx_i};
    last_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uirq_src_gate.sv
// Applies the enables to the level sources and latches the flagless events.
module uirq_src_gate
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_empty_i,
  input  logic            tx_idle_i,
  input  logic            rx_avail_i,
  input  logic            rx_ovr_i,
  input  logic            addr_evt_i,
  input  logic            wake_fall_i,
  input  logic            en_tx_empty_i,
  input  logic            en_tx_idle_i,
  input  logic            en_rx_i,
  input  logic            en_addr_i,
  input  logic            en_wake_i,
  input  logic            ack_i,
  output logic [NSRC-1:0] pend_o
);
  logic addr_q, addr_d;
  logic wake_q, wake_d;
  logic addr_set, wake_set;

  always_comb begin
    addr_set = addr_evt_i & en_addr_i;
    wake_set = wake_fall_i & en_wake_i & en_rx_i;
    // a fresh event outranks an acknowledge in the same cycle
    addr_d = addr_set | (addr_q & ~ack_i);
    wake_d = wake_set | (wake_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      wake_q <= wake_d;
    end
  end

  always_comb begin
    pend_o           = '0;
    pend_o[IDX_TXE]  = tx_empty_i & en_tx_empty_i;
    pend_o[IDX_TXI]  = tx_idle_i  & en_tx_idle_i;
    pend_o[IDX_RXA]  = rx_avail_i & en_rx_i;
    pend_o[IDX_RXO]  = rx_ovr_i   & en_rx_i;
    pend_o[IDX_ADDR] = addr_q;
    pend_o[IDX_WAKE] = wake_q;
  end
endmodule

// File: rtl/uirq_pulse_gen.sv
// Turns the merged request into fixed-length low pulses with periodic repeat.
module uirq_pulse_gen #(
  parameter int REPEAT_CYCLES = 64,
  parameter int PULSE_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_i,
  input  logic master_en_i,
  output logic int_n_o
);
  localparam int GAP_W = $clog2(REPEAT_CYCLES);
  localparam int PW    = $clog2(PULSE_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(REPEAT_CYCLES - 1);

  logic             any_q, any_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [PW-1:0]    left_q, left_d;
  logic             int_n_q, int_n_d;
  logic             rise, rearm, trig, gap_adv;

  always_comb begin
    rise    = any_i & ~any_q;
    rearm   = any_i & (gap_q == GAP_LAST);
    trig    = master_en_i & (rise | rearm);
    gap_adv = (gap_q != GAP_LAST);
    any_d   = any_i;

    gap_d = gap_q;
    if (trig)         gap_d = '0;
    else if (gap_adv) gap_d = gap_q + GAP_W'(1);

    left_d = left_q;
    if (!master_en_i)       left_d = '0;
    else if (trig)          left_d = PW'(PULSE_CYCLES);
    else if (left_q != '0)  left_d = left_q - PW'(1);

    int_n_d = (left_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q   <= 1'b0;
      gap_q   <= '0;
      left_q  <= '0;
      int_n_q <= 1'b1;
    end else begin
      any_q   <= any_d;
      gap_q   <= gap_d;
      left_q  <= left_d;
      int_n_q <= int_n_d;
    end
  end

  assign int_n_o = int_n_q;
endmodule

// File: rtl/uirq_combiner.sv
module uirq_combiner
  import uirq_pkg::*;
#(
  parameter int REPEAT_CYCLES = 64,
  parameter int PULSE_CYCLES  = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_empty_i,
  input  logic            tx_idle_i,
  input  logic            rx_avail_i,
  input  logic            rx_ovr_i,
  input  logic            addr_evt_i,
  input  logic            rx_pin_i,
  input  logic            en_tx_empty_i,
  input  logic            en_tx_idle_i,
  input  logic            en_rx_i,
  input  logic            en_addr_i,
  input  logic            en_wake_i,
  input  logic            master_en_i,
  input  logic            ack_i,
  output logic            int_n_o,
  output logic [NSRC-1:0] pend_o
);
  logic            wake_fall;
  logic [NSRC-1:0] pend;
  logic            any_pend;

  uirq_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_pin_i),
    .fall_o (wake_fall)
  );

  uirq_src_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_empty_i    (tx_empty_i),
    .tx_idle_i     (tx_idle_i),
    .rx_avail_i    (rx_avail_i),
    .rx_ovr_i      (rx_ovr_i),
    .addr_evt_i    (addr_evt_i),
    .wake_fall_i   (wake_fall),
    .en_tx_empty_i (en_tx_empty_i),
    .en_tx_idle_i  (en_tx_idle_i),
    .en_rx_i       (en_rx_i),
    .en_addr_i     (en_addr_i),
    .en_wake_i     (en_wake_i),
    .ack_i         (ack_i),
    .pend_o        (pend)
  );

  assign any_pend = |pend;

  uirq_pulse_gen #(
    .REPEAT_CYCLES (REPEAT_CYCLES),
    .PULSE_CYCLES  (PULSE_CYCLES)
  ) u_pulse (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_i       (any_pend),
    .master_en_i (master_en_i),
    .int_n_o     (int_n_o)
  );

  assign pend_o = pend;
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_evt_i,
  input logic       en_tx_empty_i,
  input logic       en_tx_idle_i,
  input logic       en_rx_i,
  input logic       en_addr_i,
  input logic       en_wake_i,
  input logic       master_en_i,
  input logic       ack_i,
  input logic       int_n_o,
  input logic [5:0] pend_o
);
  // R2: a disabled transmit source never shows as pending
  a_r2_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_tx_empty_i |-> !pend_o[0]) and (!en_tx_idle_i |-> !pend_o[1]));

  // R3: both receive sources follow the shared enable
  a_r3_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rx_i |-> (pend_o[3:2] == 2'b00));

  // R4: a latched address bit survives until acknowledged
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[4] && !ack_i |=> pend_o[4]);

  // R4: no address bit appears without an enabled event
  a_r4_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[4] && !(addr_evt_i && en_addr_i) |=> !pend_o[4]);

  // R5: wake bit needs both enables at its setting edge
  a_r5_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[5] && !(en_wake_i && en_rx_i) |=> !pend_o[5]);

  // R6: acknowledge clears the address bit unless a new event arrives
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !(addr_evt_i && en_addr_i) |=> !pend_o[4]);

  // R7: a new request pulls the line low at the next edge
  a_r7_rise_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    master_en_i && (|pend_o) && !$past(|pend_o) |=> !int_n_o);

  // R7: a pulse lasts at least a second cycle while enabled
  a_r7_two_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n_o) && master_en_i |=> !int_n_o);

  // R9: master disable holds the line high
  a_r9_master_high: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en_i |=> int_n_o);

  // R9: master disable keeps the latched wake bit
  a_r9_keeps_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en_i && pend_o[5] && !ack_i |=> pend_o[5]);
endmodule

bind uirq_combiner uirq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_evt_i    (addr_evt_i),
  .en_tx_empty_i (en_tx_empty_i),
  .en_tx_idle_i  (en_tx_idle_i),
  .en_rx_i       (en_rx_i),
  .en_addr_i     (en_addr_i),
  .en_wake_i     (en_wake_i),
  .master_en_i   (master_en_i),
  .ack_i         (ack_i),
  .int_n_o       (int_n_o),
  .pend_o        (pend_o)
);

// File: tb/uirq_combiner_tb.sv
module uirq_combiner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_empty = 0, tx_idle = 0, rx_avail = 0, rx_ovr = 0;
  logic addr_evt = 0, rx_pin = 1;
  logic en_txe = 0, en_txi = 0, en_rx = 0, en_addr = 0, en_wake = 0;
  logic master_en = 1, ack = 0;
  logic int_n;
  logic [5:0] pend;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { int at; string req; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uirq_combiner u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_empty_i(tx_empty), .tx_idle_i(tx_idle),
    .rx_avail_i(rx_avail), .rx_ovr_i(rx_ovr),
    .addr_evt_i(addr_evt), .rx_pin_i(rx_pin),
    .en_tx_empty_i(en_txe), .en_tx_idle_i(en_txi),
    .en_rx_i(en_rx), .en_addr_i(en_addr), .en_wake_i(en_wake),
    .master_en_i(master_en), .ack_i(ack),
    .int_n_o(int_n), .pend_o(pend)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_fall(int at, string req);
    exp_t e;
    e.at = at;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic chk_pend(logic [5:0] exp, string req);
    #1;
    check(pend === exp, req, "pend", int'(pend), int'(exp));
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: pops expected pulse starts and checks pulse width
  int low_cnt = 0;
  logic int_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!int_n && int_prev) begin
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected pulse at cycle", cyc, -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.at == cyc, e.req, "pulse start cycle", cyc, e.at);
        end
      end
      if (!int_n) low_cnt++;
      if (int_n && !int_prev) begin
        check(low_cnt == 2, "R7", "pulse width", low_cnt, 2);
        low_cnt = 0;
      end
    end
    int_prev = int_n;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      check(0, "WATCHDOG", "run did not end, cycle", cyc, WATCHDOG);
      report();
    end
  end

  initial begin
    int c;
    // R1: reset state
    tick(2);
    #1;
    check(int_n === 1'b1, "R1", "int_n in reset", int'(int_n), 1);
    check(pend === 6'b0, "R1", "pend in reset", int'(pend), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(3);
    #1;
    check(int_n === 1'b1, "R1", "int_n after reset", int'(int_n), 1);
    check(pend === 6'b0, "R1", "pend after reset", int'(pend), 0);

    // R7, R8: transmit-empty held long enough to repeat once
    @(negedge clk);
    c = cyc;
    en_txe = 1; tx_empty = 1;
    expect_fall(c + 1, "R7");
    expect_fall(c + 65, "R8");
    chk_pend(6'b000001, "R2");
    while (cyc < c + 70) @(negedge clk);
    tx_empty = 0;
    chk_pend(6'b000000, "R2");
    tick(70);

    // R2: transmitter idle masked, then enabled
    tx_idle = 1;
    chk_pend(6'b000000, "R2");
    tick(10);
    c = cyc;
    en_txi = 1;
    expect_fall(c + 1, "R2");
    chk_pend(6'b000010, "R2");
    tick(8);
    tx_idle = 0;
    tick(6);

    // R3: both receive levels follow one enable
    rx_avail = 1; rx_ovr = 1;
    chk_pend(6'b000000, "R3");
    tick(10);
    c = cyc;
    en_rx = 1;
    expect_fall(c + 1, "R3");
    chk_pend(6'b001100, "R3");
    tick(1);
    rx_ovr = 0;
    chk_pend(6'b000100, "R3");
    tick(6);
    rx_avail = 0;
    en_rx = 0;
    tick(6);

    // R4: disabled address event is ignored
    addr_evt = 1;
    tick(1);
    addr_evt = 0;
    chk_pend(6'b000000, "R4");
    tick(10);
    // R4: enabled address event latches and holds
    c = cyc;
    en_addr = 1; addr_evt = 1;
    expect_fall(c + 2, "R4");
    tick(1);
    addr_evt = 0;
    chk_pend(6'b010000, "R4");
    tick(10);
    chk_pend(6'b010000, "R4");
    // R6: ack clears the latch but not a live level
    en_txe = 1; tx_empty = 1; ack = 1;
    tick(1);
    ack = 0;
    chk_pend(6'b000001, "R6");
    tx_empty = 0;
    tick(10);
    // R6: event and ack in the same cycle, event wins
    c = cyc;
    addr_evt = 1; ack = 1;
    expect_fall(c + 2, "R6");
    tick(1);
    addr_evt = 0; ack = 0;
    chk_pend(6'b010000, "R6");
    tick(8);
    ack = 1;
    tick(1);
    ack = 0;
    chk_pend(6'b000000, "R6");
    en_addr = 0;
    tick(8);

    // R5: wake blocked while receive enable is off
    en_wake = 1; en_rx = 0;
    rx_pin = 0;
    tick(6);
    chk_pend(6'b000000, "R5");
    rx_pin = 1;
    tick(6);
    // R5: wake with both enables, after synchronizer latency
    en_rx = 1;
    @(negedge clk);
    c = cyc;
    rx_pin = 0;
    expect_fall(c + 4, "R5");
    tick(2);
    chk_pend(6'b000000, "R5");
    tick(1);
    chk_pend(6'b100000, "R5");
    tick(8);
    ack = 1;
    tick(1);
    ack = 0;
    tick(6);
    chk_pend(6'b000000, "R5");
    rx_pin = 1;
    tick(6);
    en_wake = 0; en_rx = 0;
    tick(70);

    // R9: master disabled, sources arrive, no pulse, state kept
    master_en = 0;
    tick(1);
    en_txe = 1; tx_empty = 1;
    en_addr = 1; addr_evt = 1;
    tick(1);
    addr_evt = 0;
    chk_pend(6'b010001, "R9");
    tick(90);
    #1;
    check(int_n === 1'b1, "R9", "int_n while disabled", int'(int_n), 1);
    chk_pend(6'b010001, "R9");
    @(negedge clk);
    c = cyc;
    master_en = 1;
    expect_fall(c + 1, "R9");
    tick(6);
    tx_empty = 0; ack = 1;
    tick(1);
    ack = 0;
    chk_pend(6'b000000, "R9");
    en_addr = 0; en_txe = 0;
    tick(80);

    check(exp_q.size() == 0, "R8", "missing pulses", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule